// File: doc/BRIEF.md
# Multi-Channel Conversion Scan Sequencer

The sequencer runs a repeating pass over up to eight logical conversion slots. Each slot carries its own setting word: which of eight physical inputs to select, unipolar or bipolar coding, a normal or calibration mode, and a gain code. One physical input may be listed in as many slots as needed. For the current slot the block drives the mux select, gain, polarity and mode lines and gives a one-cycle start pulse. It then waits for the converter's done strobe and stores the returned result in that slot's entry of a result buffer. When the last active slot has been stored, the block raises an end-of-scan level and starts the next pass at once.

Software loads a control word and eight slot words through a simple register write port. The same words can be read back. Any write to them aborts the pass in progress and restarts it from the first slot. A slot set to a calibration mode goes back to normal mode by itself once that slot's conversion has completed.

Top module: `scan_seq_top`

## Requirements
- R1: After reset one slot is active, and every slot word reads 0x08 (input code 0, bipolar, normal mode, gain 1). The control word reads 0x00, the averaging output is low and end-of-scan is low.
- R2: Register address 0 is the control word: bits [2:0] hold the index of the last active slot (active count minus one) and bit 3 enables averaging. Addresses 1 to 8 hold the words for slots 0 to 7, with bits [2:0] the input, bit 3 bipolar, bits [5:4] the mode (0 normal, 1 offset, 2 positive gain, 3 negative gain) and bits [7:6] the gain code (0 to 3 for gain 1, 2, 4, 8). Each word written reads back unchanged.
- R3: Slots are converted in ascending order from slot 0. During each one-cycle start pulse, the select, polarity, mode and gain outputs show that slot's word.
- R4: Several slots may name the same physical input, and each is converted in its own turn.
- R5: The result returned with done is stored in the buffer entry of the slot that was started, and it is readable by slot index.
- R6: End-of-scan rises the cycle after the last active slot's result is stored. It stays high until a buffer read strobe is given or until the next pass stores its slot 0 result. If slot 0 is also the last slot, the set wins.
- R7: After the last active slot the next pass starts from slot 0 with no intervening command.
- R8: A slot in a calibration mode returns its mode field to normal once its conversion is stored. Reads then show mode 0, and the next pass drives normal mode for it.
- R9: A write to any of addresses 0 to 8 aborts the pass in progress. The next cycle issues a start for slot 0, end-of-scan is cleared, and a done arriving in the same cycle as the write is discarded.
- R10: The averaging output follows control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register write address |
| regWrData | input | 8 | Register write data |
| regRdAddr | input | 4 | Register read address |
| regRdData | output | 8 | Register read data (combinational) |
| convStart | output | 1 | One-cycle start of conversion |
| muxSel | output | 3 | Physical input select for the current slot |
| gainCode | output | 2 | Gain code for the current slot |
| bipolar | output | 1 | Polarity for the current slot |
| calMode | output | 2 | Operating or calibration mode for the current slot |
| avgOn | output | 1 | Line-noise averaging enable |
| convDone | input | 1 | Conversion done strobe |
| convData | input | 24 | Conversion result, valid with done |
| bufRdAddr | input | 3 | Result buffer read index |
| bufRdEn | input | 1 | Buffer read strobe, clears end-of-scan |
| bufRdData | output | 24 | Result buffer read data |
| eos | output | 1 | End-of-scan level |

## Verification
A slot counter that skips or repeats shows up at the very next start pulse. The select and gain lines then carry a word from the wrong slot, so the scoreboard catches it on that start. A result written to the wrong entry, or an end-of-scan that rises early or late, shows up as soon as the pass ends and the buffer is read with the converter held. A calibration bit that fails to clear shows on the next pass's start for that slot and on the read port. A missed abort shows on the start pulse right after the write.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  localparam int CHAN_W = 3;

  typedef struct packed {
    logic [1:0]        gain;
    logic [1:0]        mode;
    logic              bipolar;
    logic [CHAN_W-1:0] chan;
  } slotCfg_t;

  localparam slotCfg_t SLOT_RESET = '{gain: 2'd0, mode: 2'd0, bipolar: 1'b1, chan: '0};

  typedef struct packed {
    logic store;
    logic abort;
  } seqStrobe_t;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              convDone,
  input  logic              bufRead,
  input  logic [SLOT_W-1:0] lastSlot,
  output logic              convStart,
  output logic [SLOT_W-1:0] slotIdx,
  output seqStrobe_t        strobes,
  output logic              eos
);

  typedef enum logic {ST_ISSUE, ST_WAIT} seqState_e;
  seqState_e state;
  logic      isLast;

  assign isLast        = (slotIdx == lastSlot);
  assign convStart     = (state == ST_ISSUE);
  assign strobes.abort = cfgWr;
  assign strobes.store = (state == ST_WAIT) && convDone && !cfgWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_ISSUE;
      slotIdx <= '0;
    end else if (cfgWr) begin
      state   <= ST_ISSUE;
      slotIdx <= '0;
    end else begin
      case (state)
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (convDone) begin
            state   <= ST_ISSUE;
            slotIdx <= isLast ? '0 : slotIdx + 1'b1;
          end
        end
        default: state <= ST_ISSUE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   eos <= 1'b0;
    else if (cfgWr)                              eos <= 1'b0;
    else if (strobes.store && isLast)            eos <= 1'b1;
    else if (strobes.store && slotIdx == '0)     eos <= 1'b0;
    else if (bufRead)                            eos <= 1'b0;
  end

  p_single_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && !cfgWr) |=> !convStart);
  p_restart_after_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.store |=> convStart);
  p_eos_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.store && slotIdx == lastSlot) |=> eos);
  p_eos_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (eos && !bufRead && !strobes.store && !cfgWr) |=> eos);
  p_abort_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (convStart && slotIdx == '0 && !eos));

endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 24,
  parameter int ADDR_W    = 4,
  parameter int REG_W     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int AVG_BIT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  input  seqStrobe_t        strobes,
  input  logic [SLOT_W-1:0] slotIdx,
  input  logic [DATA_W-1:0] convData,
  input  logic [SLOT_W-1:0] bufRdAddr,
  output logic              cfgWr,
  output logic [SLOT_W-1:0] lastSlot,
  output logic              avgOn,
  output slotCfg_t          curCfg,
  output logic [REG_W-1:0]  regRdData,
  output logic [DATA_W-1:0] bufRdData
);

  slotCfg_t          cfgMem [NUM_SLOTS];
  logic [DATA_W-1:0] bufMem [NUM_SLOTS];

  assign cfgWr     = regWrEn && (regAddr <= ADDR_W'(NUM_SLOTS));
  assign curCfg    = cfgMem[slotIdx];
  assign bufRdData = bufMem[bufRdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSlot <= '0;
      avgOn    <= 1'b0;
    end else if (regWrEn && regAddr == '0) begin
      lastSlot <= regWrData[SLOT_W-1:0];
      avgOn    <= regWrData[AVG_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        cfgMem[i] <= SLOT_RESET;
        bufMem[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (regWrEn && regAddr == ADDR_W'(i + 1))
          cfgMem[i] <= slotCfg_t'(regWrData);
        else if (strobes.store && slotIdx == SLOT_W'(i))
          cfgMem[i].mode <= 2'd0;
        if (strobes.store && slotIdx == SLOT_W'(i))
          bufMem[i] <= convData;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdAddr == '0) begin
      regRdData[SLOT_W-1:0] = lastSlot;
      regRdData[AVG_BIT]    = avgOn;
    end
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (regRdAddr == ADDR_W'(i + 1)) regRdData = cfgMem[i];
    end
  end

  p_store_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.store |=> bufMem[$past(slotIdx)] == $past(convData));
  p_cal_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.store && curCfg.mode != 2'd0 && !regWrEn) |=> cfgMem[$past(slotIdx)].mode == 2'd0);

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 24,
  parameter int ADDR_W    = 4,
  parameter int REG_W     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [REG_W-1:0]  regRdData,
  output logic              convStart,
  output logic [CHAN_W-1:0] muxSel,
  output logic [1:0]        gainCode,
  output logic              bipolar,
  output logic [1:0]        calMode,
  output logic              avgOn,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  input  logic [SLOT_W-1:0] bufRdAddr,
  input  logic              bufRdEn,
  output logic [DATA_W-1:0] bufRdData,
  output logic              eos
);

  seqStrobe_t        strobes;
  logic [SLOT_W-1:0] slotIdx;
  logic [SLOT_W-1:0] lastSlot;
  logic              cfgWr;
  slotCfg_t          curCfg;

  scan_seq_ctrl #(.NUM_SLOTS(NUM_SLOTS)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .convDone(convDone), .bufRead(bufRdEn),
    .lastSlot(lastSlot), .convStart(convStart), .slotIdx(slotIdx), .strobes(strobes), .eos(eos)
  );

  scan_seq_dp #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .strobes(strobes), .slotIdx(slotIdx), .convData(convData),
    .bufRdAddr(bufRdAddr), .cfgWr(cfgWr), .lastSlot(lastSlot), .avgOn(avgOn),
    .curCfg(curCfg), .regRdData(regRdData), .bufRdData(bufRdData)
  );

  assign muxSel   = curCfg.chan;
  assign gainCode = curCfg.gain;
  assign bipolar  = curCfg.bipolar;
  assign calMode  = curCfg.mode;

endmodule

// File: tb/tb_scan_seq_top.sv
`timescale 1ns/100ps
module tb_scan_seq_top;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [3:0]  regRdAddr = '0;
  logic [7:0]  regRdData;
  logic        convStart;
  logic [2:0]  muxSel;
  logic [1:0]  gainCode;
  logic        bipolar;
  logic [1:0]  calMode;
  logic        avgOn;
  logic        convDone = 1'b0;
  logic [23:0] convData = '0;
  logic [2:0]  bufRdAddr = '0;
  logic        bufRdEn = 1'b0;
  logic [23:0] bufRdData;
  logic        eos;

  scan_seq_top dut (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  logic [7:0]  shCfg [8];
  int          shLast = 0;
  int          qSlot [$];
  logic [7:0]  qCfg [$];
  logic [23:0] expBuf [8];
  bit          holdOnEos = 1;
  int          seenSlot = -1;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // converter model and scoreboard monitor
  int          cnt = 0;
  bit          busy = 0;
  int          pendSlot = -1;
  int          startNum = 0;
  logic [23:0] curData = '0;
  always @(negedge clk) begin
    if (!rstN) begin
      busy = 0; convDone = 0; pendSlot = -1;
    end else begin
      convDone = 0;
      if (convStart) begin
        startNum++;
        busy = 1; cnt = LAT;
        curData = 24'hC00000 | 24'(startNum);
        if (qSlot.size() > 0) begin
          int s;
          logic [7:0] c;
          s = qSlot.pop_front();
          c = qCfg.pop_front();
          pendSlot = s; seenSlot = s;
          chk({gainCode, calMode, bipolar, muxSel} == c, "R3 R4 R7 R8",
              $sformatf("slot %0d start word", s), {gainCode, calMode, bipolar, muxSel}, c);
        end else pendSlot = -1;
      end else if (busy && !(holdOnEos && eos)) begin
        cnt--;
        if (cnt == 0) begin
          convDone = 1; convData = curData; busy = 0;
          if (pendSlot >= 0) expBuf[pendSlot] = curData;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic pushScans(input int n);
    for (int s = 0; s < n; s++)
      for (int i = 0; i <= shLast; i++) begin
        qSlot.push_back(i);
        qCfg.push_back(shCfg[i]);
        shCfg[i][5:4] = 2'd0;   // calibration clears after one conversion
      end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    regWrEn = 1; regAddr = a; regWrData = d;
    if (a == 0) shLast = int'(d[2:0]);
    else if (a <= 8) shCfg[a-1] = d;
    @(posedge clk); #1;
    regWrEn = 0;
    qSlot.delete(); qCfg.delete();
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [7:0] exp, input string req);
    regRdAddr = a; #1;
    chk(regRdData == exp, req, $sformatf("read addr %0d", a), regRdData, exp);
  endtask

  task automatic waitEos();
    int n = 0;
    @(negedge clk);
    while (!eos && n < 3000) begin @(negedge clk); n++; end
    chk(eos == 1'b1, "R6", "end-of-scan reached", eos, 1);
  endtask

  task automatic bufChk(input int last, input string req);
    for (int i = 0; i <= last; i++) begin
      bufRdAddr = 3'(i); #1;
      chk(bufRdData == expBuf[i], req, $sformatf("buffer entry %0d", i), bufRdData, expBuf[i]);
    end
  endtask

  task automatic clearEos();
    @(posedge clk); #1 bufRdEn = 1;
    @(posedge clk); #1 bufRdEn = 0;
    @(negedge clk);
    chk(eos == 1'b0, "R6", "end-of-scan cleared by buffer read", eos, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin shCfg[i] = 8'h08; expBuf[i] = '0; end
    pushScans(1);
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    @(negedge clk);
    chk(eos == 1'b0, "R1", "eos after reset", eos, 0);
    chk(avgOn == 1'b0, "R1", "averaging after reset", avgOn, 0);
    rdChk(0, 8'h00, "R1");
    for (int i = 1; i <= 8; i++) rdChk(4'(i), 8'h08, "R1");

    // default single-slot pass
    waitEos();
    bufChk(0, "R5");
    repeat (5) @(negedge clk);
    chk(eos == 1'b1, "R6", "end-of-scan holds without read", eos, 1);
    clearEos();

    // R2 R4 R10: six slots alternating two inputs
    for (int i = 0; i < 6; i++) wrReg(4'(i + 1), 8'hC8 | 8'(i % 2));
    wrReg(7, 8'h47);
    wrReg(0, 8'h0D);
    pushScans(2);
    @(negedge clk);
    chk(avgOn == 1'b1, "R10", "averaging output", avgOn, 1);
    rdChk(0, 8'h0D, "R2");
    rdChk(7, 8'h47, "R2");
    rdChk(2, 8'hC9, "R2");
    waitEos(); bufChk(5, "R4"); clearEos();
    waitEos(); bufChk(5, "R5"); clearEos();

    // R8 calibration slot
    wrReg(2, 8'hE9);
    pushScans(2);
    waitEos(); bufChk(5, "R8"); clearEos();
    rdChk(2, 8'hC9, "R8");
    waitEos(); clearEos();
    wrReg(0, 8'h05);
    chk(avgOn == 1'b0, "R10", "averaging off", avgOn, 0);

    // R6 next pass slot 0 store clears end-of-scan
    holdOnEos = 0;
    pushScans(2);
    waitEos();
    begin
      int n = 0;
      while (eos && n < 50) begin @(negedge clk); n++; end
      chk(n == LAT + 1, "R6", "cycles until next pass clears eos", n, LAT + 1);
    end

    // R9 abort mid-pass
    wrReg(0, 8'h03);
    pushScans(1);
    while (seenSlot != 2) @(negedge clk);
    wrReg(0, 8'h03);
    pushScans(1);
    @(negedge clk);
    chk(convStart == 1'b1 && muxSel == shCfg[0][2:0], "R9", "restart at slot 0",
        {convStart, muxSel}, {1'b1, shCfg[0][2:0]});
    holdOnEos = 1;
    waitEos(); bufChk(3, "R9");
    wrReg(1, 8'h4B);
    pushScans(1);
    @(negedge clk);
    chk(eos == 1'b0, "R9", "abort clears end-of-scan", eos, 0);
    waitEos(); bufChk(3, "R9");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule